// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state of a bank of interrupt sources and turns events on their input lines into delivery requests for a presentation layer. Each source stores a destination server, a current priority, a saved priority and four status flags. A parameter marks each source as level-type or message-type, and the two types follow different rules for when a request is raised. Source numbers are absolute: source index `i` answers to number `BASE + i`.

The presentation layer sends back three kinds of notice. A reject marks a source as turned away. A resend asks every source to try delivery again. An end-of-interrupt closes a level source's delivery. A small command port lets firmware route a source, read it back, and disable or enable it. Disable parks the priority in the saved field and enable brings it back, so there is no separate enable bit. Delivery requests leave one per cycle through a valid/ready handshake. When several requests are pending, the lowest source index goes first.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset no delivery and no response is pending. Every source reads back server 0 and priority 0xFF, where 0xFF means masked.
- R2: A rising edge on an unmasked message source's line issues one delivery carrying that source's server, its number `BASE+i` and its priority.
- R3: A rising edge on a masked message source sets masked-pending (status bit 3) and delivers nothing. A later routing write with a priority below 0xFF clears that flag and delivers once. A repeated write does not deliver again.
- R4: A level source's line sets or clears asserted (bit 0). It delivers only when it is unmasked, asserted and not sent (bit 1), and it sets sent when it does. Toggling the line while sent delivers nothing.
- R5: A reject naming a source sets rejected (bit 2) and clears sent. A resend then redelivers an asserted, unmasked level source.
- R6: A resend clears rejected on message sources and redelivers those that are unmasked. A second resend delivers nothing, and a masked rejected source is dropped.
- R7: An end-of-interrupt clears sent on a level source and delivers nothing by itself. On a message source it has no effect: a rejected message source is still redelivered by the next resend.
- R8: Disable (op 2) sets the priority to 0xFF and saves the old one. Enable (op 3) restores it. A message edge while disabled is delivered after enable, at the restored priority.
- R9: A command is refused (ok low) when the number is outside `[BASE, BASE+NUM_SRC)`. A routing write (op 0) is also refused when the server is not below `NUM_SRV` or the priority exceeds 0xFF. A refused command changes no state.
- R10: A delivery is held stable while `dlv_ready` is low. Deliveries pending together leave in ascending source order, one per accepted cycle.
- R11: Every command receives a response one cycle later. A query (op 1) returns the source's server and priority. Writes return the values they stored.
- R12: Reject and end-of-interrupt notices naming numbers outside the bank are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NUM_SRC | Source input lines, bit i for source BASE+i |
| rej_valid | input | 1 | Reject notice strobe |
| rej_src | input | SRC_W | Source number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_src | input | SRC_W | Source number being closed |
| resend_req | input | 1 | Resend strobe for all sources |
| cfg_valid | input | 1 | Command strobe |
| cfg_op | input | 2 | 0 route, 1 query, 2 disable, 3 enable |
| cfg_src | input | SRC_W | Command source number |
| cfg_server | input | SRV_IN_W | Requested server for route |
| cfg_prio | input | 9 | Requested priority for route |
| rsp_valid | output | 1 | Command response strobe |
| rsp_ok | output | 1 | Command accepted |
| rsp_server | output | SRV_W | Server returned by the command |
| rsp_prio | output | 8 | Priority returned by the command |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Presentation layer takes the request |
| dlv_server | output | SRV_W | Destination server |
| dlv_src | output | SRC_W | Source number |
| dlv_prio | output | 8 | Delivery priority |

## Verification
The bench builds the block with eight sources at base 0x20 and four servers. The lower four sources are message-type and the upper four are level-type, so both state machines run side by side in one bank. With a base other than zero, the numbers just below and just above the bank, 0x1F and 0x28, become cheap boundary cases. With four servers, server index 4 is the first illegal value. A short window with `dlv_ready` held low gathers three redeliveries at once, which exposes both the ordering and the hold behaviour.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  typedef enum logic [1:0] {
    OP_ROUTE  = 2'd0,
    OP_QUERY  = 2'd1,
    OP_MUTE   = 2'd2,
    OP_UNMUTE = 2'd3
  } cfg_op_e;

  localparam logic [7:0] PRIO_OFF = 8'hFF;

  // status flag positions
  localparam int ST_ASSERTED = 0;
  localparam int ST_SENT     = 1;
  localparam int ST_REJ      = 2;
  localparam int ST_MPEND    = 3;
  localparam int ST_W        = 4;

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter int SRV_W    = 2,
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_in,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             resend,
  input  logic             wr_en,
  input  logic [SRV_W-1:0] wr_server,
  input  logic [7:0]       wr_prio,
  input  logic [7:0]       wr_saved,
  input  logic             grant,
  output logic [SRV_W-1:0] server_o,
  output logic [7:0]       prio_o,
  output logic [7:0]       saved_o,
  output logic             dq_o
);

  logic             line_q;
  logic [SRV_W-1:0] srv_q, srv_d;
  logic [7:0]       pr_q, pr_d, sv_q, sv_d;
  logic [ST_W-1:0]  st_q, st_d;
  logic             dq_q, dq_d, req;

  // Events apply in a fixed order: line, reject, end-of-interrupt, write, resend.
  always_comb begin
    srv_d = srv_q;
    pr_d  = pr_q;
    sv_d  = sv_q;
    st_d  = st_q;
    req   = 1'b0;

    if (IS_LEVEL) begin
      if (line_in != line_q) begin
        st_d[ST_ASSERTED] = line_in;
        if (pr_d != PRIO_OFF && st_d[ST_ASSERTED] && !st_d[ST_SENT]) begin
          st_d[ST_SENT] = 1'b1;
          req           = 1'b1;
        end
      end
    end else if (line_in && !line_q) begin
      if (pr_d == PRIO_OFF) st_d[ST_MPEND] = 1'b1;
      else                  req            = 1'b1;
    end

    if (rej_hit) begin
      st_d[ST_REJ]  = 1'b1;
      st_d[ST_SENT] = 1'b0;
    end

    if (eoi_hit && IS_LEVEL) st_d[ST_SENT] = 1'b0;

    if (wr_en) begin
      srv_d = wr_server;
      pr_d  = wr_prio;
      sv_d  = wr_saved;
      if (IS_LEVEL) begin
        if (pr_d != PRIO_OFF && st_d[ST_ASSERTED] && !st_d[ST_SENT]) begin
          st_d[ST_SENT] = 1'b1;
          req           = 1'b1;
        end
      end else if (st_d[ST_MPEND] && pr_d != PRIO_OFF) begin
        st_d[ST_MPEND] = 1'b0;
        req            = 1'b1;
      end
    end

    if (resend) begin
      if (IS_LEVEL) begin
        if (pr_d != PRIO_OFF && st_d[ST_ASSERTED] && !st_d[ST_SENT]) begin
          st_d[ST_SENT] = 1'b1;
          req           = 1'b1;
        end
      end else if (st_d[ST_REJ]) begin
        st_d[ST_REJ] = 1'b0;
        if (pr_d != PRIO_OFF) req = 1'b1;
      end
    end

    dq_d = (dq_q && !grant) || req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b0;
      srv_q  <= '0;
      pr_q   <= PRIO_OFF;
      sv_q   <= PRIO_OFF;
      st_q   <= '0;
      dq_q   <= 1'b0;
    end else begin
      line_q <= line_in;
      srv_q  <= srv_d;
      pr_q   <= pr_d;
      sv_q   <= sv_d;
      st_q   <= st_d;
      dq_q   <= dq_d;
    end
  end

  assign server_o = srv_q;
  assign prio_o   = pr_q;
  assign saved_o  = sv_q;
  assign dq_o     = dq_q;

endmodule

// File: rtl/irq_cfg_unit.sv
module irq_cfg_unit
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int BASE     = 16,
  parameter int SRC_W    = 16,
  parameter int SRV_IN_W = 8,
  parameter int NUM_SRV  = 4,
  parameter int SRV_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_valid,
  input  logic [1:0]          cfg_op,
  input  logic [SRC_W-1:0]    cfg_src,
  input  logic [SRV_IN_W-1:0] cfg_server,
  input  logic [8:0]          cfg_prio,
  input  logic [SRV_W-1:0]    slot_srv [NUM_SRC],
  input  logic [7:0]          slot_pr  [NUM_SRC],
  input  logic [7:0]          slot_sv  [NUM_SRC],
  output logic [NUM_SRC-1:0]  wr_en,
  output logic [SRV_W-1:0]    wr_server,
  output logic [7:0]          wr_prio,
  output logic [7:0]          wr_saved,
  output logic                rsp_valid,
  output logic                rsp_ok,
  output logic [SRV_W-1:0]    rsp_server,
  output logic [7:0]          rsp_prio
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [SRV_IN_W:0] SRV_LIM = (SRV_IN_W + 1)'(NUM_SRV);

  logic [NUM_SRC-1:0] hit;
  logic [IDX_W-1:0]   idx;
  logic               ok;
  cfg_op_e            op;

  always_comb begin
    hit = '0;
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cfg_src == SRC_W'(BASE + i)) begin
        hit[i] = 1'b1;
        idx    = IDX_W'(i);
      end
    end
  end

  always_comb begin
    op        = cfg_op_e'(cfg_op);
    ok        = |hit;
    wr_server = slot_srv[idx];
    wr_prio   = slot_pr[idx];
    wr_saved  = slot_sv[idx];
    unique case (op)
      OP_ROUTE: begin
        ok        = ok && ({1'b0, cfg_server} < SRV_LIM) && !cfg_prio[8];
        wr_server = cfg_server[SRV_W-1:0];
        wr_prio   = cfg_prio[7:0];
        wr_saved  = cfg_prio[7:0];
      end
      OP_MUTE: begin
        wr_prio  = PRIO_OFF;
        wr_saved = slot_pr[idx];
      end
      OP_UNMUTE: begin
        wr_prio  = slot_sv[idx];
        wr_saved = slot_sv[idx];
      end
      default: ;
    endcase
    wr_en = (cfg_valid && ok && op != OP_QUERY) ? hit : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_server <= '0;
      rsp_prio   <= '0;
    end else begin
      rsp_valid  <= cfg_valid;
      rsp_ok     <= cfg_valid && ok;
      rsp_server <= ok ? wr_server : '0;
      rsp_prio   <= ok ? wr_prio : '0;
    end
  end

endmodule

// File: rtl/irq_dlv_arb.sv
module irq_dlv_arb #(
  parameter int NUM_SRC = 16,
  parameter int BASE    = 16,
  parameter int SRC_W   = 16,
  parameter int SRV_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [SRV_W-1:0]   slot_srv [NUM_SRC],
  input  logic [7:0]         slot_pr  [NUM_SRC],
  input  logic               dlv_ready,
  output logic [NUM_SRC-1:0] grant,
  output logic               dlv_valid,
  output logic [SRV_W-1:0]   dlv_server,
  output logic [SRC_W-1:0]   dlv_src,
  output logic [7:0]         dlv_prio
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] sel;
  logic             any, free;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) sel = IDX_W'(i);
    end
    any   = |pend;
    free  = !dlv_valid || dlv_ready;
    grant = (free && any) ? (ONE << sel) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_server <= '0;
      dlv_src    <= '0;
      dlv_prio   <= '0;
    end else if (free) begin
      dlv_valid <= any;
      if (any) begin
        dlv_server <= slot_srv[sel];
        dlv_src    <= SRC_W'(BASE) + SRC_W'(sel);
        dlv_prio   <= slot_pr[sel];
      end
    end
  end

endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import irq_src_pkg::*;
#(
  parameter int                 NUM_SRC    = 16,
  parameter int                 BASE       = 16,
  parameter int                 SRC_W      = 16,
  parameter int                 NUM_SRV    = 4,
  parameter int                 SRV_IN_W   = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0,
  localparam int                SRV_W      = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_line,
  input  logic                rej_valid,
  input  logic [SRC_W-1:0]    rej_src,
  input  logic                eoi_valid,
  input  logic [SRC_W-1:0]    eoi_src,
  input  logic                resend_req,
  input  logic                cfg_valid,
  input  logic [1:0]          cfg_op,
  input  logic [SRC_W-1:0]    cfg_src,
  input  logic [SRV_IN_W-1:0] cfg_server,
  input  logic [8:0]          cfg_prio,
  output logic                rsp_valid,
  output logic                rsp_ok,
  output logic [SRV_W-1:0]    rsp_server,
  output logic [7:0]          rsp_prio,
  output logic                dlv_valid,
  input  logic                dlv_ready,
  output logic [SRV_W-1:0]    dlv_server,
  output logic [SRC_W-1:0]    dlv_src,
  output logic [7:0]          dlv_prio
);

  logic [SRV_W-1:0]   slot_srv [NUM_SRC];
  logic [7:0]         slot_pr  [NUM_SRC];
  logic [7:0]         slot_sv  [NUM_SRC];
  logic [NUM_SRC-1:0] pend, grant, wr_en;
  logic [SRV_W-1:0]   wr_server;
  logic [7:0]         wr_prio, wr_saved;

  irq_cfg_unit #(
    .NUM_SRC(NUM_SRC), .BASE(BASE), .SRC_W(SRC_W),
    .SRV_IN_W(SRV_IN_W), .NUM_SRV(NUM_SRV), .SRV_W(SRV_W)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_src(cfg_src),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .slot_srv(slot_srv), .slot_pr(slot_pr), .slot_sv(slot_sv),
    .wr_en(wr_en), .wr_server(wr_server), .wr_prio(wr_prio), .wr_saved(wr_saved),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_server(rsp_server), .rsp_prio(rsp_prio)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    logic rej_hit, eoi_hit;
    assign rej_hit = rej_valid && (rej_src == SRC_W'(BASE + g));
    assign eoi_hit = eoi_valid && (eoi_src == SRC_W'(BASE + g));

    irq_src_slot #(
      .SRV_W(SRV_W), .IS_LEVEL(LEVEL_MASK[g])
    ) u_slot (
      .clk(clk), .rst(rst),
      .line_in(src_line[g]), .rej_hit(rej_hit), .eoi_hit(eoi_hit),
      .resend(resend_req), .wr_en(wr_en[g]),
      .wr_server(wr_server), .wr_prio(wr_prio), .wr_saved(wr_saved),
      .grant(grant[g]),
      .server_o(slot_srv[g]), .prio_o(slot_pr[g]), .saved_o(slot_sv[g]),
      .dq_o(pend[g])
    );
  end

  irq_dlv_arb #(
    .NUM_SRC(NUM_SRC), .BASE(BASE), .SRC_W(SRC_W), .SRV_W(SRV_W)
  ) u_arb (
    .clk(clk), .rst(rst), .pend(pend),
    .slot_srv(slot_srv), .slot_pr(slot_pr),
    .dlv_ready(dlv_ready), .grant(grant),
    .dlv_valid(dlv_valid), .dlv_server(dlv_server),
    .dlv_src(dlv_src), .dlv_prio(dlv_prio)
  );

endmodule

// File: rtl/irq_source_ctrl_chk.sv
module irq_source_ctrl_chk #(
  parameter int NUM_SRC  = 16,
  parameter int BASE     = 16,
  parameter int SRC_W    = 16,
  parameter int NUM_SRV  = 4,
  parameter int SRV_IN_W = 8,
  parameter int SRV_W    = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_valid,
  input logic [1:0]          cfg_op,
  input logic [SRV_IN_W-1:0] cfg_server,
  input logic [8:0]          cfg_prio,
  input logic                rsp_valid,
  input logic                rsp_ok,
  input logic                dlv_valid,
  input logic                dlv_ready,
  input logic [SRV_W-1:0]    dlv_server,
  input logic [SRC_W-1:0]    dlv_src,
  input logic [7:0]          dlv_prio
);

  localparam logic [SRC_W-1:0]    LO  = SRC_W'(BASE);
  localparam logic [SRC_W-1:0]    HI  = SRC_W'(BASE + NUM_SRC);
  localparam logic [SRV_IN_W:0]   LIM = (SRV_IN_W + 1)'(NUM_SRV);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!dlv_valid && !rsp_valid));

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=>
      (dlv_valid && $stable(dlv_src) && $stable(dlv_prio) && $stable(dlv_server)));

  a_r10_src_in_bank: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (dlv_src >= LO && dlv_src < HI));

  a_r11_rsp_after_cmd: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> rsp_valid);

  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(cfg_valid));

  a_r9_bad_server: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_op == 2'd0 && {1'b0, cfg_server} >= LIM) |=> !rsp_ok);

  a_r9_bad_prio: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_op == 2'd0 && cfg_prio[8]) |=> !rsp_ok);

endmodule

bind irq_source_ctrl irq_source_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .BASE(BASE), .SRC_W(SRC_W),
  .NUM_SRV(NUM_SRV), .SRV_IN_W(SRV_IN_W), .SRV_W(SRV_W)
) u_chk (
  .clk(clk), .rst(rst),
  .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
  .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
  .dlv_server(dlv_server), .dlv_src(dlv_src), .dlv_prio(dlv_prio)
);

// File: tb/irq_source_ctrl_bench.sv
`timescale 1ns/1ps
module irq_source_ctrl_bench;

  localparam int N        = 8;
  localparam int BASE     = 32;
  localparam int SRC_W    = 16;
  localparam int NUM_SRV  = 4;
  localparam int SRV_IN_W = 8;
  localparam int SRV_W    = 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [N-1:0]        src_line = '0;
  logic                rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0;
  logic [SRC_W-1:0]    rej_src = '0, eoi_src = '0, cfg_src = '0;
  logic                cfg_valid = 1'b0;
  logic [1:0]          cfg_op = '0;
  logic [SRV_IN_W-1:0] cfg_server = '0;
  logic [8:0]          cfg_prio = '0;
  logic                rsp_valid, rsp_ok, dlv_valid;
  logic                dlv_ready = 1'b1;
  logic [SRV_W-1:0]    rsp_server, dlv_server;
  logic [7:0]          rsp_prio, dlv_prio;
  logic [SRC_W-1:0]    dlv_src;

  irq_source_ctrl #(
    .NUM_SRC(N), .BASE(BASE), .SRC_W(SRC_W), .NUM_SRV(NUM_SRV),
    .SRV_IN_W(SRV_IN_W), .LEVEL_MASK(8'hF0)
  ) u_irq_source_ctrl (
    .clk(clk), .rst(rst), .src_line(src_line),
    .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_src(cfg_src),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_server(rsp_server), .rsp_prio(rsp_prio),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_server(dlv_server),
    .dlv_src(dlv_src), .dlv_prio(dlv_prio)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  logic [31:0] expq[$];
  string       tagq[$];

  task automatic chk(input bit cond, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && dlv_valid && dlv_ready) begin
      logic [31:0] got;
      got = {6'd0, dlv_server, dlv_src, dlv_prio};
      if (expq.size() == 0) chk(1'b0, "R10", "unexpected delivery", got, 0);
      else begin
        logic [31:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(got == e, t, "delivery {srv,src,prio}", got, e);
      end
    end
  end

  task automatic expect_dlv(input int srv, input int src, input int prio, input string tag);
    expq.push_back({8'(srv), 16'(src), 8'(prio)});
    tagq.push_back(tag);
  endtask

  task automatic drain(input string tag);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, tag, "outstanding expected deliveries", expq.size(), 0);
    expq.delete();
    tagq.delete();
  endtask

  task automatic cfg(input logic [1:0] op, input int src, input int srv, input int prio,
                     input bit eok, input int esrv, input int eprio, input string tag);
    cfg_valid  = 1'b1;
    cfg_op     = op;
    cfg_src    = SRC_W'(src);
    cfg_server = SRV_IN_W'(srv);
    cfg_prio   = 9'(prio);
    @(negedge clk);
    cfg_valid = 1'b0;
    chk(rsp_valid == 1'b1, tag, "response valid", rsp_valid, 1);
    chk(rsp_ok == eok, tag, "response ok", rsp_ok, eok);
    if (eok) begin
      chk(rsp_server == SRV_W'(esrv), tag, "response server", rsp_server, esrv);
      chk(rsp_prio == 8'(eprio), tag, "response priority", rsp_prio, eprio);
    end
  endtask

  task automatic pulse_line(input int i);
    src_line[i] = 1'b1;
    @(negedge clk);
    src_line[i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_line(input int i, input logic v);
    src_line[i] = v;
    @(negedge clk);
  endtask

  task automatic do_reject(input int src);
    rej_valid = 1'b1; rej_src = SRC_W'(src);
    @(negedge clk);
    rej_valid = 1'b0;
  endtask

  task automatic do_eoi(input int src);
    eoi_valid = 1'b1; eoi_src = SRC_W'(src);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic do_resend();
    resend_req = 1'b1;
    @(negedge clk);
    resend_req = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(dlv_valid == 1'b0, "R1", "delivery idle after reset", dlv_valid, 0);
    chk(rsp_valid == 1'b0, "R1", "response idle after reset", rsp_valid, 0);
    cfg(2'd1, 'h23, 0, 0, 1, 0, 'hFF, "R1");
    cfg(2'd1, 'h27, 0, 0, 1, 0, 'hFF, "R1");

    // R2 / R11
    cfg(2'd0, 'h21, 2, 5, 1, 2, 5, "R11");
    expect_dlv(2, 'h21, 5, "R2");
    pulse_line(1);
    drain("R2");

    // R3 masked-pending
    pulse_line(2);
    drain("R3");
    expect_dlv(1, 'h22, 3, "R3");
    cfg(2'd0, 'h22, 1, 3, 1, 1, 3, "R3");
    drain("R3");
    cfg(2'd0, 'h22, 1, 3, 1, 1, 3, "R3");
    drain("R3");

    // R4 level rule
    cfg(2'd0, 'h24, 3, 7, 1, 3, 7, "R4");
    drain("R4");
    expect_dlv(3, 'h24, 7, "R4");
    set_line(4, 1'b1);
    drain("R4");
    set_line(4, 1'b0);
    set_line(4, 1'b1);
    drain("R4");

    // R7 level end-of-interrupt
    do_eoi('h24);
    drain("R7");
    expect_dlv(3, 'h24, 7, "R7");
    do_resend();
    drain("R7");

    // R5 reject of a level source
    do_reject('h24);
    drain("R5");
    expect_dlv(3, 'h24, 7, "R5");
    do_resend();
    drain("R5");

    // R6 message resend
    do_reject('h21);
    expect_dlv(2, 'h21, 5, "R6");
    do_resend();
    drain("R6");
    do_resend();
    drain("R6");

    // R7 end-of-interrupt on message source has no effect
    do_reject('h21);
    do_eoi('h21);
    expect_dlv(2, 'h21, 5, "R7");
    do_resend();
    drain("R7");

    // R6 masked rejected message is dropped
    cfg(2'd2, 'h22, 0, 0, 1, 1, 'hFF, "R6");
    do_reject('h22);
    do_resend();
    drain("R6");
    cfg(2'd3, 'h22, 0, 0, 1, 1, 3, "R6");
    do_resend();
    drain("R6");

    // R8 disable / enable
    cfg(2'd2, 'h21, 0, 0, 1, 2, 'hFF, "R8");
    cfg(2'd1, 'h21, 0, 0, 1, 2, 'hFF, "R8");
    pulse_line(1);
    drain("R8");
    expect_dlv(2, 'h21, 5, "R8");
    cfg(2'd3, 'h21, 0, 0, 1, 2, 5, "R8");
    drain("R8");

    // R9 range checks
    cfg(2'd0, 'h28, 1, 1, 0, 0, 0, "R9");
    cfg(2'd0, 'h1F, 1, 1, 0, 0, 0, "R9");
    cfg(2'd0, 'h21, 4, 1, 0, 0, 0, "R9");
    cfg(2'd0, 'h21, 1, 'h100, 0, 0, 0, "R9");
    cfg(2'd1, 'h40, 0, 0, 0, 0, 0, "R9");
    cfg(2'd1, 'h21, 0, 0, 1, 2, 5, "R9");
    drain("R9");

    // R12 notices outside the bank
    do_reject('h30);
    do_eoi('h10);
    do_resend();
    drain("R12");

    // R10 ordering and hold under backpressure
    cfg(2'd0, 'h20, 0, 1, 1, 0, 1, "R10");
    cfg(2'd0, 'h23, 1, 2, 1, 1, 2, "R10");
    drain("R10");
    do_reject('h23);
    do_reject('h20);
    do_reject('h21);
    dlv_ready = 1'b0;
    expect_dlv(0, 'h20, 1, "R10");
    expect_dlv(2, 'h21, 5, "R10");
    expect_dlv(1, 'h23, 2, "R10");
    do_resend();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(dlv_valid == 1'b1 && dlv_src == SRC_W'('h20), "R10",
          "held delivery source", dlv_src, 'h20);
    end
    dlv_ready = 1'b1;
    drain("R10");

    summary();
    $finish;
  end

endmodule